// File: doc/BRIEF.md
# Three-wire serial EEPROM command engine

This block is the device-side logic of a small serial EEPROM. A host drives chip select, a serial clock and a data line. The block sees these as inputs that are already synchronous to its system clock. It decodes the serial instructions and keeps the contents in an internal register file. That array has 2^WORD_AW words of 16 bits. An organization input picks whether the host sees it as 16-bit words or as 8-bit bytes.

Every modifying instruction is gated by a write-enable latch, which is clear after reset. An accepted modify starts a self-timed program cycle. The program cycle is a counter of PROG_CYCLES system clocks. While it runs, the block ignores new instructions. A host that drops chip select and raises it again can poll the data-out line: it reads 0 while busy and 1 once the cycle has finished. Data out also has an output-enable signal that stands in for tri-state.

Top module: `ee3w_engine`

## Requirements
- R1: After chip select rises, zeros on the data line are skipped. The first 1 sampled on a serial-clock rising edge is the start bit. Two opcode bits follow, then the address, MSB first. The address is WORD_AW bits when org_i=1 and WORD_AW+1 bits when org_i=0.
- R2: Opcode 10 reads. Data out is enabled and drives 0 from the edge that takes the last address bit. The word then appears MSB first, one bit per later rising edge. Reads work whatever the state of the enable latch.
- R3: The enable latch is clear after reset. Opcode 00 with top address bits 11 sets it. Opcode 00 with top bits 00 clears it. While it is clear, no write, erase, erase-all or write-all changes the array or starts a program cycle.
- R4: Opcode 01 stores the data bits that follow the address: 16 in word mode, 8 in byte mode.
- R5: Opcode 11 sets the addressed location to all ones. The cycle starts right after the address.
- R6: Opcode 00 with top bits 10 sets the whole array to ones. Opcode 00 with top bits 01 writes the supplied pattern into every location. In byte mode the byte pattern fills both halves of every word.
- R7: In byte mode, bit 0 of the byte address selects the low byte (0) or the high byte (1) of word address[WORD_AW:1]. A byte read returns 8 bits.
- R8: A program cycle lasts PROG_CYCLES system clocks from the edge that completes the instruction. Any instruction sent during it is ignored.
- R9: When chip select falls and rises again during a program cycle, data out is enabled. It reads 0 until the cycle ends and then reads 1.
- R10: While chip select is low, output enable is low one clock later. Dropping chip select aborts a partial instruction without changing the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock, sampled on its rising edge |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | 1: 16-bit words, 0: 8-bit bytes |
| do_o | output | 1 | Serial data out / ready-busy status |
| do_oe_o | output | 1 | Output enable for data out |

## Verification
Two things can meet in one cycle. The program timer can expire on the same clock that the status phase samples busy. A start bit can also arrive while the status phase is still showing busy. The bench provokes the first by polling the status line clock by clock after a write and checking that the 0-to-1 change falls within one clock of PROG_CYCLES after the final data edge. It provokes the second by sending a complete write during the status phase of an earlier write. A later read must show that this second write left its target untouched while the first write landed.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_HOLD,
        ST_STATUS
    } fsm_e;

    typedef enum logic [1:0] {
        AOP_NONE,
        AOP_ONE,
        AOP_ALL
    } aop_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_WDIS  = 2'b00;
    localparam logic [1:0] SUB_WALL  = 2'b01;
    localparam logic [1:0] SUB_EALL  = 2'b10;
    localparam logic [1:0] SUB_WEN   = 2'b11;

    localparam int WORD_BITS = 16;
    localparam int LANE_BITS = 8;
endpackage

// File: rtl/ee3w_edge.sv
module ee3w_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sk_i,
    input  logic cs_i,
    output logic sk_rise_o,
    output logic cs_rise_o
);
    typedef struct packed {
        logic sk;
        logic cs;
    } hist_s;

    hist_s hist_d, hist_q;

    always_comb begin
        hist_d.sk = sk_i;
        hist_d.cs = cs_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= hist_d;
    end

    assign sk_rise_o = sk_i & ~hist_q.sk;
    assign cs_rise_o = cs_i & ~hist_q.cs;
endmodule

// File: rtl/ee3w_timer.sv
module ee3w_timer #(
    parameter int PROG_CYCLES = 40
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)             cnt_d = LOAD;
        else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ee3w_array.sv
module ee3w_array
    import ee3w_pkg::*;
#(
    parameter int WORD_AW = 8,
    parameter int DW      = WORD_BITS
) (
    input  logic               clk_i,
    input  aop_e               op_kind_i,
    input  logic [WORD_AW-1:0] op_idx_i,
    input  logic [DW-1:0]      op_data_i,
    input  logic [DW/LANE_BITS-1:0] op_mask_i,
    input  logic [WORD_AW-1:0] rd_idx_i,
    output logic [DW-1:0]      rd_data_o
);
    localparam int DEPTH = 1 << WORD_AW;
    localparam int LANES = DW / LANE_BITS;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        case (op_kind_i)
            AOP_ONE: begin
                for (int l = 0; l < LANES; l++) begin
                    if (op_mask_i[l])
                        mem[op_idx_i][l*LANE_BITS +: LANE_BITS] <= op_data_i[l*LANE_BITS +: LANE_BITS];
                end
            end
            AOP_ALL: begin
                for (int i = 0; i < DEPTH; i++) begin
                    for (int l = 0; l < LANES; l++) begin
                        if (op_mask_i[l])
                            mem[i][l*LANE_BITS +: LANE_BITS] <= op_data_i[l*LANE_BITS +: LANE_BITS];
                    end
                end
            end
            default: ;
        endcase
    end

    assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/ee3w_engine.sv
module ee3w_engine
    import ee3w_pkg::*;
#(
    parameter int WORD_AW     = 8,
    parameter int PROG_CYCLES = 40
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic org_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int DW      = WORD_BITS;
    localparam int LANES   = DW / LANE_BITS;
    localparam int BYTE_AW = WORD_AW + 1;
    localparam int CNT_W   = $clog2(DW + BYTE_AW + 1);

    typedef struct packed {
        fsm_e               st;
        logic [CNT_W-1:0]   cnt;
        logic [1:0]         opc;
        logic [BYTE_AW-1:0] addr;
        logic [DW-1:0]      sreg;
        logic               wen;
        logic               dout;
        logic               oe;
    } eng_s;

    eng_s d, q;

    logic sk_rise, cs_rise, busy, prog_start;
    aop_e aop_kind;
    logic [WORD_AW-1:0] aop_idx, rd_idx;
    logic [DW-1:0]      aop_data, rd_word;
    logic [LANES-1:0]   aop_mask;

    logic [BYTE_AW-1:0] addr_n;
    logic [DW-1:0]      sreg_n, rd_sel, data_n;
    logic [WORD_AW-1:0] widx_n, widx_q;
    logic [LANES-1:0]   lane_n, lane_q;
    logic [1:0]         sub;
    logic [CNT_W-1:0]   aw_last, dw_last;
    fsm_e               st_cur;

    ee3w_edge u_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sk_i     (sk_i),
        .cs_i     (cs_i),
        .sk_rise_o(sk_rise),
        .cs_rise_o(cs_rise)
    );

    ee3w_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(prog_start),
        .busy_o (busy)
    );

    ee3w_array #(.WORD_AW(WORD_AW), .DW(DW)) u_array (
        .clk_i    (clk_i),
        .op_kind_i(aop_kind),
        .op_idx_i (aop_idx),
        .op_data_i(aop_data),
        .op_mask_i(aop_mask),
        .rd_idx_i (rd_idx),
        .rd_data_o(rd_word)
    );

    always_comb begin
        addr_n  = {q.addr[BYTE_AW-2:0], di_i};
        sreg_n  = {q.sreg[DW-2:0], di_i};
        widx_n  = org_i ? addr_n[WORD_AW-1:0] : addr_n[BYTE_AW-1:1];
        widx_q  = org_i ? q.addr[WORD_AW-1:0] : q.addr[BYTE_AW-1:1];
        lane_n  = org_i ? {LANES{1'b1}} : (addr_n[0] ? 2'b10 : 2'b01);
        lane_q  = org_i ? {LANES{1'b1}} : (q.addr[0] ? 2'b10 : 2'b01);
        sub     = org_i ? addr_n[WORD_AW-1 -: 2] : addr_n[BYTE_AW-1 -: 2];
        aw_last = org_i ? CNT_W'(WORD_AW - 1) : CNT_W'(BYTE_AW - 1);
        dw_last = org_i ? CNT_W'(DW - 1) : CNT_W'(LANE_BITS - 1);
        rd_idx  = widx_n;
        if (org_i)          rd_sel = rd_word;
        else if (addr_n[0]) rd_sel = {rd_word[DW-1 -: LANE_BITS], {LANE_BITS{1'b0}}};
        else                rd_sel = {rd_word[LANE_BITS-1:0], {LANE_BITS{1'b0}}};
        data_n  = org_i ? sreg_n : {LANES{sreg_n[LANE_BITS-1:0]}};
    end

    always_comb begin
        d          = q;
        aop_kind   = AOP_NONE;
        aop_idx    = '0;
        aop_data   = '0;
        aop_mask   = '0;
        prog_start = 1'b0;

        if (!cs_i) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.dout = 1'b0;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (cs_rise && busy) begin
                        d.st   = ST_STATUS;
                        d.oe   = 1'b1;
                        d.dout = ~busy;
                    end else if (!busy && sk_rise && di_i) begin
                        d.st  = ST_OPC;
                        d.cnt = '0;
                    end
                end
                ST_STATUS: begin
                    d.oe   = 1'b1;
                    d.dout = ~busy;
                    if (!busy && sk_rise && di_i) begin
                        d.st   = ST_OPC;
                        d.cnt  = '0;
                        d.oe   = 1'b0;
                        d.dout = 1'b0;
                    end
                end
                ST_OPC: begin
                    if (sk_rise) begin
                        d.opc = {q.opc[0], di_i};
                        if (q.cnt == CNT_W'(1)) begin
                            d.st   = ST_ADDR;
                            d.cnt  = '0;
                            d.addr = '0;
                        end else begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_ADDR: begin
                    if (sk_rise) begin
                        d.addr = addr_n;
                        if (q.cnt == aw_last) begin
                            d.cnt = '0;
                            d.st  = ST_HOLD;
                            case (q.opc)
                                OPC_READ: begin
                                    d.st   = ST_READ;
                                    d.oe   = 1'b1;
                                    d.dout = 1'b0;
                                    d.sreg = rd_sel;
                                end
                                OPC_ERASE: begin
                                    if (q.wen) begin
                                        aop_kind   = AOP_ONE;
                                        aop_idx    = widx_n;
                                        aop_data   = '1;
                                        aop_mask   = lane_n;
                                        prog_start = 1'b1;
                                    end
                                end
                                OPC_WRITE: begin
                                    d.st   = ST_DATA;
                                    d.sreg = '0;
                                end
                                default: begin
                                    case (sub)
                                        SUB_WEN:  d.wen = 1'b1;
                                        SUB_WDIS: d.wen = 1'b0;
                                        SUB_EALL: begin
                                            if (q.wen) begin
                                                aop_kind   = AOP_ALL;
                                                aop_data   = '1;
                                                aop_mask   = '1;
                                                prog_start = 1'b1;
                                            end
                                        end
                                        default: begin
                                            d.st   = ST_DATA;
                                            d.sreg = '0;
                                        end
                                    endcase
                                end
                            endcase
                        end else begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_DATA: begin
                    if (sk_rise) begin
                        d.sreg = sreg_n;
                        if (q.cnt == dw_last) begin
                            d.st  = ST_HOLD;
                            d.cnt = '0;
                            if (q.wen) begin
                                aop_data   = data_n;
                                prog_start = 1'b1;
                                if (q.opc == OPC_WRITE) begin
                                    aop_kind = AOP_ONE;
                                    aop_idx  = widx_q;
                                    aop_mask = lane_q;
                                end else begin
                                    aop_kind = AOP_ALL;
                                    aop_mask = '1;
                                end
                            end
                        end else begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_READ: begin
                    if (sk_rise) begin
                        d.dout = q.sreg[DW-1];
                        d.sreg = {q.sreg[DW-2:0], 1'b0};
                    end
                end
                ST_HOLD: ;
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign st_cur  = q.st;
    assign do_o    = q.dout;
    assign do_oe_o = q.oe;
endmodule

// File: rtl/ee3w_chk.sv
module ee3w_chk
    import ee3w_pkg::*;
(
    input logic clk_i,
    input logic rst_ni,
    input logic cs_i,
    input logic do_o,
    input logic do_oe_o,
    input logic busy_i,
    input logic start_i,
    input fsm_e st_i
);
    // R10
    oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_i |=> !do_oe_o);

    // R8
    no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> !start_i);

    // R8
    busy_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_i);

    // R9
    status_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_STATUS) |-> (do_oe_o && (do_o == !$past(busy_i))));

    // R2
    dummy_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_READ && $past(st_i) == ST_ADDR) |-> (do_oe_o && !do_o));
endmodule

bind ee3w_engine ee3w_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_i),
    .do_o   (do_o),
    .do_oe_o(do_oe_o),
    .busy_i (busy),
    .start_i(prog_start),
    .st_i   (st_cur)
);

// File: tb/ee3w_engine_tb.sv
`timescale 1ns/1ps
module ee3w_engine_tb;
    localparam int WAW = 4;
    localparam int PC  = 400;
    localparam int NW  = 1 << WAW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic do_o, do_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic [15:0] mdl [NW];

    always #2.5 clk = ~clk;

    ee3w_engine #(.WORD_AW(WAW), .PROG_CYCLES(PC)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .org_i(org), .do_o(do_o), .do_oe_o(do_oe)
    );

    task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        @(negedge clk); di = b; sk = 1'b0;
        tick(3); sk = 1'b1;
        tick(3);
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic cs_on();
        @(negedge clk); cs = 1'b1; sk = 1'b0; tick(2);
    endtask

    task automatic cs_off();
        @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0; tick(3);
    endtask

    function automatic int awid();
        return org ? WAW : WAW + 1;
    endfunction

    function automatic int dwid();
        return org ? 16 : 8;
    endfunction

    task automatic cmd(input logic [1:0] op, input int a, input logic [15:0] dat, input bit has_dat);
        cs_on();
        sbit(1'b1);
        send({14'd0, op}, 2);
        send(16'(a), awid());
        if (has_dat) send(dat, dwid());
    endtask

    task automatic wait_ready();
        cs_off();
        cs_on();
        for (int i = 0; i < PC + 20 && do_oe && !do_o; i++) tick(1);
        cs_off();
    endtask

    task automatic rd(input int a, input int lead, output logic [15:0] v);
        v = '0;
        cs_on();
        for (int i = 0; i < lead; i++) sbit(1'b0);
        sbit(1'b1); sbit(1'b1); sbit(1'b0);
        send(16'(a), awid());
        chk("R2 dummy", {14'd0, do_oe, do_o}, 16'h0002);
        for (int i = 0; i < dwid(); i++) begin
            sbit(1'b0);
            v = {v[14:0], do_o};
        end
        cs_off();
        chk("R10 oe after cs low", {15'd0, do_oe}, 16'h0000);
    endtask

    function automatic logic [15:0] expect_at(input int a, input logic o);
        if (o) return mdl[a];
        return a[0] ? {8'h00, mdl[a >> 1][15:8]} : {8'h00, mdl[a >> 1][7:0]};
    endfunction

    task automatic read_all(input string r);
        logic [15:0] v;
        for (int a = 0; a < (org ? NW : 2 * NW); a++) begin
            rd(a, 0, v);
            chk(r, v, expect_at(a, org));
        end
    endtask

    task automatic set_wen(input bit en);
        int a;
        a = (en ? 3 : 0) << (awid() - 2);
        cmd(2'b00, a, 16'h0, 1'b0);
        cs_off();
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
        tick(4); rst_n = 1'b1; tick(2);
    endtask

    initial begin
        logic [15:0] v;
        int k;
        tick(5); rst_n = 1'b1; tick(2);
        chk("R10 reset oe", {15'd0, do_oe}, 16'h0000);
        chk("R10 reset do", {15'd0, do_o}, 16'h0000);

        // R6 erase-all in word mode
        org = 1'b1;
        set_wen(1'b1);
        cmd(2'b00, 2 << (WAW - 2), 16'h0, 1'b0); wait_ready();
        for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
        read_all("R6 erase-all");

        // R9 status timing after a write to word 3
        cmd(2'b01, 3, 16'hBEEF, 1'b1);
        mdl[3] = 16'hBEEF;
        k = 3;
        cs_off(); k += 4;
        cs_on(); k += 3;
        chk("R9 busy status", {14'd0, do_oe, do_o}, 16'h0002);
        while (!do_o && k < PC + 40) begin tick(1); k++; end
        chk("R9 ready lo bound", {15'd0, (k >= PC + 1)}, 16'h0001);
        chk("R9 ready hi bound", {15'd0, (k <= PC + 3)}, 16'h0001);
        chk("R9 ready oe", {15'd0, do_oe}, 16'h0001);
        cs_off();

        // R4 word write sweep
        for (int i = 0; i < NW; i++) begin
            mdl[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
            cmd(2'b01, i, mdl[i], 1'b1); wait_ready();
        end
        read_all("R4 word write");

        // R8 command during busy is ignored
        cmd(2'b01, 2, 16'h0F0F, 1'b1); mdl[2] = 16'h0F0F;
        cs_off(); cs_on();
        chk("R9 busy status 2", {14'd0, do_oe, do_o}, 16'h0002);
        sbit(1'b1); send(16'h1, 2); send(16'd9, WAW); send(16'hDEAD, 16);
        for (int i = 0; i < PC + 20 && !do_o; i++) tick(1);
        cs_off();
        rd(2, 0, v); chk("R4 first write landed", v, 16'h0F0F);
        rd(9, 0, v); chk("R8 busy-time write ignored", v, mdl[9]);

        // R1 leading zeros before start bit
        rd(4, 3, v); chk("R1 leading zeros", v, mdl[4]);

        // R5 erase one word
        cmd(2'b11, 5, 16'h0, 1'b0); wait_ready(); mdl[5] = 16'hFFFF;
        rd(5, 0, v); chk("R5 erased", v, 16'hFFFF);
        rd(4, 0, v); chk("R5 neighbour low", v, mdl[4]);
        rd(6, 0, v); chk("R5 neighbour high", v, mdl[6]);

        // R6 write-all
        cmd(2'b00, 1 << (WAW - 2), 16'h3C96, 1'b1); wait_ready();
        for (int i = 0; i < NW; i++) mdl[i] = 16'h3C96;
        read_all("R6 write-all");

        // R3 disabled latch blocks every modify
        set_wen(1'b0);
        cmd(2'b01, 7, 16'h1111, 1'b1); cs_off(); cs_on();
        chk("R3 no busy after blocked write", {15'd0, do_oe}, 16'h0000);
        cs_off();
        cmd(2'b11, 8, 16'h0, 1'b0); wait_ready();
        cmd(2'b00, 2 << (WAW - 2), 16'h0, 1'b0); wait_ready();
        cmd(2'b00, 1 << (WAW - 2), 16'h0000, 1'b1); wait_ready();
        read_all("R3 disabled");

        // R10 aborted write
        set_wen(1'b1);
        cs_on(); sbit(1'b1); send(16'h1, 2); send(16'd1, WAW); send(16'h0, 5);
        cs_off();
        chk("R10 oe low on abort", {15'd0, do_oe}, 16'h0000);
        rd(1, 0, v); chk("R10 abort left word", v, mdl[1]);
        cmd(2'b01, 1, 16'h7E81, 1'b1); wait_ready(); mdl[1] = 16'h7E81;
        rd(1, 0, v); chk("R10 command after abort", v, 16'h7E81);

        // R7 byte mode sweep
        org = 1'b0;
        for (int a = 0; a < 2 * NW; a++) begin
            logic [7:0] b;
            b = 8'(a * 37 + 11);
            cmd(2'b01, a, {8'h00, b}, 1'b1); wait_ready();
            if (a[0]) mdl[a >> 1][15:8] = b; else mdl[a >> 1][7:0] = b;
        end
        read_all("R7 byte read");
        org = 1'b1;
        read_all("R7 word layout");

        // R5 byte erase keeps the other half
        org = 1'b0;
        cmd(2'b11, 6, 16'h0, 1'b0); wait_ready(); mdl[3][7:0] = 8'hFF;
        org = 1'b1;
        rd(3, 0, v); chk("R5 byte erase", v, mdl[3]);

        // R6 write-all in byte mode
        org = 1'b0;
        cmd(2'b00, 1 << (WAW - 1), 16'h005A, 1'b1); wait_ready();
        for (int i = 0; i < NW; i++) mdl[i] = 16'h5A5A;
        org = 1'b1;
        read_all("R6 byte write-all");

        // R3 latch clear after reset
        cmd(2'b00, 1 << (WAW - 2), 16'h0000, 1'b1); wait_ready();
        for (int i = 0; i < NW; i++) mdl[i] = 16'h0000;
        pulse_reset();
        chk("R3 oe after reset", {15'd0, do_oe}, 16'h0000);
        cmd(2'b00, 2 << (WAW - 2), 16'h0, 1'b0); wait_ready();
        rd(0, 0, v); chk("R3 reset latch word0", v, 16'h0000);
        rd(NW - 1, 0, v); chk("R3 reset latch last", v, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule